// File: doc/BRIEF.md
# SIMD Register Move and Duplicate Unit

This unit performs the 128-bit vector move family used by a SIMD execution pipe: full-width copies of four singles or two doubles, scalar single moves that either merge into or zero-extend the destination, and two duplicate forms. The duplicate forms replicate either the even or the odd 32-bit lanes into adjacent pairs. Upstream decode presents a prefix class, the second opcode byte, a flag saying that the r/m operand is memory, the source value and the current destination value. All of these are qualified by a strobe.

One cycle after the strobe, the unit presents either a register write-back value with a write enable, or store data with a byte-enable mask. For an unknown prefix/opcode pair it raises an invalid-operation flag and produces neither.

Prefix classes are encoded as 0 = no prefix, 1 = 66, 2 = F3, 3 = F2. The opcode byte is the one that follows 0F.

Top module: `simd_move_unit`

## Requirements
- R1: Prefix F3 with opcode 16h writes source bits [63:32] into result lanes [31:0] and [63:32], and source bits [127:96] into lanes [95:64] and [127:96].
- R2: Prefix F3 with opcode 12h writes source bits [31:0] into result lanes [31:0] and [63:32], and source bits [95:64] into lanes [95:64] and [127:96].
- R3: Prefix F3 with opcode 10h from a register source, or opcode 11h to a register destination, writes source [31:0] to result [31:0] and keeps destination bits [127:32].
- R4: Prefix F3 with opcode 10h from a memory source writes source [31:0] to result [31:0] and clears result bits [127:32].
- R5: Prefix F3 with opcode 11h and a memory operand asserts the store enable, not the write enable. Store data [31:0] equals source [31:0], store data [127:32] is zero, and the byte enable is 000Fh.
- R6: Prefix 66 or no prefix, with opcode 10h (either operand kind) or 11h with a register operand, writes the full 128-bit source unchanged.
- R7: Prefix 66 or no prefix, with opcode 11h and a memory operand, stores the full source with byte enable FFFFh and no register write.
- R8: Any other prefix/opcode pair (including F2, and 12h/16h without F3) raises invalid_op with neither write nor store enable.
- R9: out_valid pulses exactly one cycle after each in_valid. The write, store and invalid flags are low whenever out_valid is low.
- R10: During and straight after reset, all output flags are low and all data outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation strobe |
| pfx | input | 2 | Prefix class (0 none, 1 66, 2 F3, 3 F2) |
| opc | input | 8 | Opcode byte after 0F |
| rm_is_mem | input | 1 | r/m operand is memory |
| src_data | input | 128 | Source register or loaded value |
| dst_data | input | 128 | Current destination register value |
| out_valid | output | 1 | Result presented this cycle |
| wr_en | output | 1 | Register write-back enable |
| result | output | 128 | Write-back value |
| st_en | output | 1 | Store enable |
| st_data | output | 128 | Store data |
| st_be | output | 16 | Store byte enables |
| invalid_op | output | 1 | Unknown prefix/opcode pair |

## Verification
Two things can occupy the same cycle. One is the presentation of operation N's registered result. The other is the capture of operation N+1, which may be of a different kind: a merge after a store, or an invalid pair after a duplicate. The bench issues long runs of back-to-back strobes whose kinds and operand types are drawn at random, with idle gaps mixed in. A behavioural model predicts each cycle's outputs from the inputs sampled at the previous edge. Every field is compared at each falling edge, so a flag or value leaking from one operation into the next is caught.

// File: rtl/smu_pkg.sv
package smu_pkg;
  localparam int VW = 128;
  localparam int LW = 32;
  localparam int NL = VW / LW;
  localparam int NB = VW / 8;
  localparam int SB = LW / 8;

  typedef enum logic [1:0] {PFX_NONE = 2'd0, PFX_66 = 2'd1, PFX_F3 = 2'd2, PFX_F2 = 2'd3} pfx_e;
  typedef enum logic [2:0] {
    OP_BAD, OP_FULL_WR, OP_FULL_ST, OP_SS_WR, OP_SS_ST, OP_DUP_LO, OP_DUP_HI
  } op_e;

  // Replicate the even (take_odd=0) or odd (take_odd=1) lane of each pair.
  function automatic logic [VW-1:0] dup_pairs(input logic [VW-1:0] v, input logic take_odd);
    logic [VW-1:0] r;
    for (int p = 0; p < NL / 2; p++) begin
      r[(2*p)*LW +: LW]   = v[(2*p + int'(take_odd))*LW +: LW];
      r[(2*p+1)*LW +: LW] = v[(2*p + int'(take_odd))*LW +: LW];
    end
    return r;
  endfunction

  // Low lane from src; upper lanes kept from dst or cleared.
  function automatic logic [VW-1:0] scalar_lane(input logic [VW-1:0] dst,
                                                input logic [VW-1:0] src,
                                                input logic clear_hi);
    logic [VW-1:0] r;
    r = clear_hi ? '0 : dst;
    r[LW-1:0] = src[LW-1:0];
    return r;
  endfunction
endpackage

// File: rtl/smu_decode.sv
module smu_decode
  import smu_pkg::*;
(
  input  logic [1:0] pfx,
  input  logic [7:0] opc,
  input  logic       rm_is_mem,
  output op_e        op
);
  localparam logic [7:0] OPC_LD  = 8'h10;
  localparam logic [7:0] OPC_ST  = 8'h11;
  localparam logic [7:0] OPC_DLO = 8'h12;
  localparam logic [7:0] OPC_DHI = 8'h16;

  always_comb begin
    op = OP_BAD;
    unique case (pfx_e'(pfx))
      PFX_NONE, PFX_66: begin
        if (opc == OPC_LD)      op = OP_FULL_WR;
        else if (opc == OPC_ST) op = rm_is_mem ? OP_FULL_ST : OP_FULL_WR;
      end
      PFX_F3: begin
        if (opc == OPC_LD)       op = OP_SS_WR;
        else if (opc == OPC_ST)  op = rm_is_mem ? OP_SS_ST : OP_SS_WR;
        else if (opc == OPC_DLO) op = OP_DUP_LO;
        else if (opc == OPC_DHI) op = OP_DUP_HI;
      end
      default: op = OP_BAD;
    endcase
  end
endmodule

// File: rtl/smu_lanes.sv
module smu_lanes
  import smu_pkg::*;
(
  input  op_e             op,
  input  logic            rm_is_mem,
  input  logic [VW-1:0]   src_data,
  input  logic [VW-1:0]   dst_data,
  output logic            wr,
  output logic            st,
  output logic            bad,
  output logic [VW-1:0]   res,
  output logic [VW-1:0]   sdata,
  output logic [NB-1:0]   sbe
);
  localparam logic [NB-1:0] BE_SCALAR = NB'((1 << SB) - 1);

  always_comb begin
    wr    = 1'b0;
    st    = 1'b0;
    bad   = 1'b0;
    res   = '0;
    sdata = '0;
    sbe   = '0;
    unique case (op)
      OP_FULL_WR: begin wr = 1'b1; res = src_data; end
      OP_FULL_ST: begin st = 1'b1; sdata = src_data; sbe = '1; end
      OP_SS_WR:   begin wr = 1'b1; res = scalar_lane(dst_data, src_data, rm_is_mem); end
      OP_SS_ST:   begin st = 1'b1; sdata = scalar_lane('0, src_data, 1'b1); sbe = BE_SCALAR; end
      OP_DUP_LO:  begin wr = 1'b1; res = dup_pairs(src_data, 1'b0); end
      OP_DUP_HI:  begin wr = 1'b1; res = dup_pairs(src_data, 1'b1); end
      default:    bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/simd_move_unit.sv
module simd_move_unit
  import smu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    pfx,
  input  logic [7:0]    opc,
  input  logic          rm_is_mem,
  input  logic [127:0]  src_data,
  input  logic [127:0]  dst_data,
  output logic          out_valid,
  output logic          wr_en,
  output logic [127:0]  result,
  output logic          st_en,
  output logic [127:0]  st_data,
  output logic [15:0]   st_be,
  output logic          invalid_op
);
  op_e             dec_op;
  logic            nx_wr, nx_st, nx_bad;
  logic [VW-1:0]   nx_res, nx_sdata;
  logic [NB-1:0]   nx_be;
  logic            scalar_mem_load;

  smu_decode u_dec (.pfx(pfx), .opc(opc), .rm_is_mem(rm_is_mem), .op(dec_op));

  smu_lanes u_lanes (
    .op(dec_op), .rm_is_mem(rm_is_mem), .src_data(src_data), .dst_data(dst_data),
    .wr(nx_wr), .st(nx_st), .bad(nx_bad), .res(nx_res), .sdata(nx_sdata), .sbe(nx_be)
  );

  assign scalar_mem_load = in_valid && (dec_op == OP_SS_WR) && rm_is_mem && (opc == 8'h10);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      wr_en      <= 1'b0;
      st_en      <= 1'b0;
      invalid_op <= 1'b0;
      result     <= '0;
      st_data    <= '0;
      st_be      <= '0;
    end else begin
      out_valid  <= in_valid;
      wr_en      <= in_valid && nx_wr;
      st_en      <= in_valid && nx_st;
      invalid_op <= in_valid && nx_bad;
      if (in_valid) begin
        result  <= nx_res;
        st_data <= nx_sdata;
        st_be   <= nx_be;
      end
    end
  end

  // R9: presentation follows a strobe by exactly one cycle
  p_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));
  p_quiet_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (!wr_en && !st_en && !invalid_op));
  // R8: invalid pairs never write nor store
  p_invalid_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_op |-> (!wr_en && !st_en));
  // R5: a store never also writes the register
  p_store_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && st_en));
  // R7: store mask is either whole vector or one lane
  p_be_shape_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st_en |-> (st_be == 16'hFFFF || st_be == 16'h000F));
  // R4: a scalar memory load leaves upper bits clear
  p_zero_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    scalar_mem_load |=> (wr_en && result[127:32] == '0));
endmodule

// File: tb/simd_move_unit_tb.sv
`timescale 1ns/1ps
module simd_move_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] pfx = '0;
  logic [7:0] opc = '0;
  logic rm_is_mem = 1'b0;
  logic [127:0] src_data = '0, dst_data = '0;
  logic out_valid, wr_en, st_en, invalid_op;
  logic [127:0] result, st_data;
  logic [15:0] st_be;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  simd_move_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .pfx(pfx), .opc(opc),
    .rm_is_mem(rm_is_mem), .src_data(src_data), .dst_data(dst_data),
    .out_valid(out_valid), .wr_en(wr_en), .result(result), .st_en(st_en),
    .st_data(st_data), .st_be(st_be), .invalid_op(invalid_op)
  );

  // expected outputs, updated at each rising edge
  logic e_v, e_wr, e_st, e_bad;
  logic [127:0] e_res, e_sd;
  logic [15:0] e_be;
  string e_tag;
  logic [127:0] last_res = '0, last_sd = '0;
  logic [15:0] last_be = '0;

  function automatic logic [31:0] lane(input logic [127:0] v, input int i);
    return v[i*32 +: 32];
  endfunction

  always @(posedge clk) begin
    e_v = 0; e_wr = 0; e_st = 0; e_bad = 0; e_tag = "R9";
    e_res = last_res; e_sd = last_sd; e_be = last_be;
    if (!rst_n) begin
      e_tag = "R10"; e_res = '0; e_sd = '0; e_be = '0;
    end else if (in_valid) begin
      e_v = 1; e_res = '0; e_sd = '0; e_be = '0;
      if (pfx == 2 && opc == 8'h16) begin
        e_tag = "R1"; e_wr = 1;
        e_res = {lane(src_data,3), lane(src_data,3), lane(src_data,1), lane(src_data,1)};
      end else if (pfx == 2 && opc == 8'h12) begin
        e_tag = "R2"; e_wr = 1;
        e_res = {lane(src_data,2), lane(src_data,2), lane(src_data,0), lane(src_data,0)};
      end else if (pfx == 2 && opc == 8'h10 && rm_is_mem) begin
        e_tag = "R4"; e_wr = 1; e_res = {96'h0, lane(src_data,0)};
      end else if (pfx == 2 && (opc == 8'h10 || (opc == 8'h11 && !rm_is_mem))) begin
        e_tag = "R3"; e_wr = 1; e_res = {dst_data[127:32], lane(src_data,0)};
      end else if (pfx == 2 && opc == 8'h11) begin
        e_tag = "R5"; e_st = 1; e_sd = {96'h0, lane(src_data,0)}; e_be = 16'h000F;
      end else if (pfx < 2 && opc == 8'h11 && rm_is_mem) begin
        e_tag = "R7"; e_st = 1; e_sd = src_data; e_be = 16'hFFFF;
      end else if (pfx < 2 && (opc == 8'h10 || opc == 8'h11)) begin
        e_tag = "R6"; e_wr = 1; e_res = src_data;
      end else begin
        e_tag = "R8"; e_bad = 1;
      end
    end
    if (!rst_n || in_valid) begin
      last_res = e_res; last_sd = e_sd; last_be = e_be;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (e_tag != "") begin
      chk(out_valid === e_v, "R9", "out_valid", 128'(out_valid), 128'(e_v));
      chk(wr_en === e_wr, e_tag, "wr_en", 128'(wr_en), 128'(e_wr));
      chk(st_en === e_st, e_tag, "st_en", 128'(st_en), 128'(e_st));
      chk(invalid_op === e_bad, e_tag, "invalid_op", 128'(invalid_op), 128'(e_bad));
      chk(result === e_res, e_tag, "result", result, e_res);
      chk(st_data === e_sd, e_tag, "st_data", st_data, e_sd);
      chk(st_be === e_be, e_tag, "st_be", 128'(st_be), 128'(e_be));
    end
  end

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic issue(input logic [1:0] p, input logic [7:0] o, input logic m);
    @(negedge clk); #1;
    in_valid = 1; pfx = p; opc = o; rm_is_mem = m;
    src_data = rnd128(); dst_data = rnd128();
  endtask

  task automatic idle();
    @(negedge clk); #1;
    in_valid = 0; src_data = rnd128(); dst_data = rnd128();
  endtask

  initial begin
    e_tag = "";
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    // directed: each form once (R1..R8)
    issue(2, 8'h16, 0); issue(2, 8'h16, 1);
    issue(2, 8'h12, 0); issue(2, 8'h12, 1);
    issue(2, 8'h10, 0); issue(2, 8'h10, 1);
    issue(2, 8'h11, 0); issue(2, 8'h11, 1);
    issue(1, 8'h10, 1); issue(0, 8'h10, 0); issue(1, 8'h11, 0);
    issue(0, 8'h11, 1); issue(1, 8'h11, 1);
    issue(3, 8'h10, 0); issue(0, 8'h12, 0); issue(1, 8'h16, 1); issue(2, 8'h13, 0);
    idle(); idle();
    // mixed back-to-back with gaps
    for (int i = 0; i < 400; i++) begin
      logic [7:0] ops [6] = '{8'h10, 8'h11, 8'h12, 8'h16, 8'h13, 8'h00};
      if ($urandom_range(0, 4) == 0) idle();
      else issue(2'($urandom_range(0, 3)), ops[$urandom_range(0, 5)], 1'($urandom_range(0, 1)));
    end
    idle(); idle();
    // reset mid-stream (R10)
    issue(2, 8'h16, 0);
    @(negedge clk); #1 rst_n = 0; in_valid = 0;
    repeat (2) @(negedge clk);
    #1 rst_n = 1;
    idle(); idle();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule